// File: doc/BRIEF.md
# Microcontroller Instruction Sequencer

This block is the program-flow half of a small 8-bit soft microcontroller. It owns the program counter, a 31-entry hardware return stack with its hidden pointer, and the interrupt-enable bit. It drives a 10-bit program address, takes back an 18-bit instruction word, and executes the flow-control instructions itself: jump, call and return, each with a conditional form, plus return-from-interrupt and interrupt enable/disable. Conditional forms test only the zero and carry flags, which the execution side supplies. Every other instruction is handed to the execution side as decoded operand fields with a one-cycle valid strobe.

Each instruction takes exactly two cycles. The controller has three states. ST_FETCH presents the program counter and latches the instruction word. ST_EXEC decodes that word and updates the program counter, the stack and the enable bit. ST_IACK acknowledges an interrupt. The transitions are as follows. ST_FETCH always goes to ST_EXEC. ST_EXEC goes to ST_IACK when the interrupt input is high and the enable bit, as updated by the instruction that just executed, is set. Otherwise ST_EXEC goes to ST_FETCH. ST_IACK always goes to ST_FETCH.

Branch targets are always absolute: there is no branch adder and no computed jump. Software cannot read the stack contents, the stack pointer or the enable bit.

Top module: `instr_sequencer`

## Requirements
- R1: While reset is high and on release: prog_addr is 0, irq_ack and op_valid are low, the interrupt-enable bit is clear and the return stack is empty.
- R2: prog_addr holds its value across the fetch and execute cycles of an instruction, and changes only at the end of the execute cycle, so each instruction takes exactly two cycles.
- R3: Any instruction that does not redirect flow leaves the next address at the current address plus one, modulo 1024 (0x3FF is followed by 0x000).
- R4: Encoding: the opcode is instr_word[17:12] and the absolute target is instr_word[9:0]. The opcodes are 0x20 jump, 0x21 call, 0x22 return, 0x23 return-from-interrupt, 0x24 set interrupt enable, 0x28 conditional jump, 0x29 conditional call and 0x2A conditional return. A taken jump loads the target directly.
- R5: Conditional forms use instr_word[11:10] as the condition: 00 means zero flag set, 01 zero clear, 10 carry set, 11 carry clear. A false condition behaves as R3.
- R6: A taken call pushes the current address plus one and loads the target. A taken return pops the most recent entry into the program counter, in LIFO order.
- R7: The return stack has 31 entries. Its pointer wraps modulo 31 on both push and pop, so a 32nd push overwrites the oldest entry, and a pop continues around the ring. No error is signalled.
- R8: An interrupt is taken at the end of an instruction when irq is high and the enable bit is set. irq_ack is then high for exactly one cycle, the address of the next instruction is pushed, the enable bit is cleared and execution continues at 0x3FF. The acknowledge comes no later than five cycles after irq rises with the enable bit set. While the enable bit is clear, irq has no effect.
- R9: Return-from-interrupt pops the return address and sets the enable bit to instr_word[0]. Opcode 0x24 sets the enable bit to instr_word[0] and continues at the next address.
- R10: Any opcode whose bits [5:4] are not 10 goes to the execution side. op_valid is high during its execute cycle only, with op_code = instr_word[17:12], op_dst = [11:8], op_src = [7:4] and op_imm = [7:0]. Flow-control opcodes (0x20 to 0x2F) never raise op_valid, and unlisted ones among them act as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_addr | output | 10 | Program memory address |
| instr_word | input | 18 | Instruction read from program memory |
| flag_zero | input | 1 | Zero flag from the execution side |
| flag_carry | input | 1 | Carry flag from the execution side |
| irq | input | 1 | Interrupt request |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| op_valid | output | 1 | Operand fields valid for the execution side |
| op_code | output | 6 | Operation code for the execution side |
| op_dst | output | 4 | Destination register index |
| op_src | output | 4 | Source register index |
| op_imm | output | 8 | Immediate value or port address |

## Verification
The bench drives a chain of 32 nested calls followed by a run of returns. A stack that is one entry too deep, or one that saturates instead of wrapping, would return to address 1 instead of looping back to 32. The bench walks every condition code with its flag both true and false. An inverted or swapped condition decode would branch on the wrong flag. It raises irq with the enable bit clear, enables the interrupt while the request is pending, and returns from the interrupt with the enable bit both set and cleared. A sequencer that pushed the wrong return address, left the enable bit set, or acknowledged late would then land on the wrong address or fail the latency bound. The bench also jumps to 0x3FF to confirm that the program counter rolls over to zero.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int OPC_W = 6;
    localparam int REG_W = 4;
    localparam int IMM_W = 8;

    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h20;
    localparam logic [OPC_W-1:0] OPC_CALL  = 6'h21;
    localparam logic [OPC_W-1:0] OPC_RET   = 6'h22;
    localparam logic [OPC_W-1:0] OPC_RETI  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_IESET = 6'h24;
    localparam logic [OPC_W-1:0] OPC_JUMPC = 6'h28;
    localparam logic [OPC_W-1:0] OPC_CALLC = 6'h29;
    localparam logic [OPC_W-1:0] OPC_RETC  = 6'h2A;

    typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_IACK} seq_state_t;

    typedef enum logic [2:0] {
        FLOW_NEXT, FLOW_JUMP, FLOW_CALL, FLOW_RET, FLOW_RETI, FLOW_IESET
    } flow_t;

    function automatic logic cond_met(input logic [1:0] sel,
                                      input logic z, input logic c);
        unique case (sel)
            2'b00: cond_met = z;
            2'b01: cond_met = !z;
            2'b10: cond_met = c;
            default: cond_met = !c;
        endcase
    endfunction
endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic [1:0]       cond_sel,
    input  logic             flag_z,
    input  logic             flag_c,
    output flow_t            flow,
    output logic             is_alu
);
    logic cond_ok;

    always_comb begin
        cond_ok = cond_met(cond_sel, flag_z, flag_c);
        is_alu  = (opc[OPC_W-1 -: 2] != 2'b10);
        flow    = FLOW_NEXT;
        if (!is_alu) begin
            unique case (opc)
                OPC_JUMP:  flow = FLOW_JUMP;
                OPC_CALL:  flow = FLOW_CALL;
                OPC_RET:   flow = FLOW_RET;
                OPC_RETI:  flow = FLOW_RETI;
                OPC_IESET: flow = FLOW_IESET;
                OPC_JUMPC: flow = cond_ok ? FLOW_JUMP : FLOW_NEXT;
                OPC_CALLC: flow = cond_ok ? FLOW_CALL : FLOW_NEXT;
                OPC_RETC:  flow = cond_ok ? FLOW_RET  : FLOW_NEXT;
                default:   flow = FLOW_NEXT;
            endcase
        end
    end
endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
    parameter int DEPTH = 31,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_up, ptr_dn;

    assign ptr_up   = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
    assign ptr_dn   = (ptr_q == '0) ? LAST : ptr_q - PTR_W'(1);
    assign top_data = slots[ptr_dn];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (push) begin
            slots[ptr_q] <= push_data;
            ptr_q        <= ptr_up;
        end else if (pop) begin
            ptr_q <= ptr_dn;
        end
    end

    assert_ptr_range_R7: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= LAST);
    assert_push_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        push |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + PTR_W'(1)));
    assert_pop_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> ptr_q == (($past(ptr_q) == '0) ? LAST : $past(ptr_q) - PTR_W'(1)));
    assert_no_push_pop_R6: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
    import seq_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int INSTR_W     = 18,
    parameter int STACK_DEPTH = 31,
    parameter logic [ADDR_W-1:0] VECTOR_ADDR = {ADDR_W{1'b1}}
) (
    input  logic               clk,
    input  logic               rst,
    output logic [ADDR_W-1:0]  prog_addr,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               flag_zero,
    input  logic               flag_carry,
    input  logic               irq,
    output logic               irq_ack,
    output logic               op_valid,
    output logic [OPC_W-1:0]   op_code,
    output logic [REG_W-1:0]   op_dst,
    output logic [REG_W-1:0]   op_src,
    output logic [IMM_W-1:0]   op_imm
);
    localparam int OPC_LSB  = INSTR_W - OPC_W;
    localparam int DST_LSB  = IMM_W;
    localparam int COND_LSB = ADDR_W;

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] pc_q, pc_d, pc_inc;
    logic [INSTR_W-1:0] ir_q;
    logic              ie_q, ie_d;
    logic              stk_push, stk_pop;
    logic [ADDR_W-1:0] stk_wdata, stk_top;
    flow_t             flow;
    logic              is_alu;

    seq_decode u_dec (
        .opc      (ir_q[OPC_LSB +: OPC_W]),
        .cond_sel (ir_q[COND_LSB +: 2]),
        .flag_z   (flag_zero),
        .flag_c   (flag_carry),
        .flow     (flow),
        .is_alu   (is_alu)
    );

    seq_ret_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data (stk_wdata),
        .top_data  (stk_top)
    );

    assign pc_inc    = pc_q + ADDR_W'(1);
    assign prog_addr = pc_q;
    assign op_code   = ir_q[OPC_LSB +: OPC_W];
    assign op_dst    = ir_q[DST_LSB +: REG_W];
    assign op_src    = ir_q[IMM_W-1 -: REG_W];
    assign op_imm    = ir_q[IMM_W-1:0];

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        unique case (state_q)
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC:  state_d = (irq && ie_d) ? ST_IACK : ST_FETCH;
            ST_IACK:  state_d = ST_FETCH;
            default:  state_d = ST_FETCH;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        pc_d      = pc_q;
        ie_d      = ie_q;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        stk_wdata = pc_inc;
        irq_ack   = 1'b0;
        op_valid  = 1'b0;
        unique case (state_q)
            ST_FETCH: ;
            ST_EXEC: begin
                op_valid = is_alu;
                pc_d     = pc_inc;
                unique case (flow)
                    FLOW_JUMP: pc_d = ir_q[ADDR_W-1:0];
                    FLOW_CALL: begin
                        stk_push = 1'b1;
                        pc_d     = ir_q[ADDR_W-1:0];
                    end
                    FLOW_RET: begin
                        stk_pop = 1'b1;
                        pc_d    = stk_top;
                    end
                    FLOW_RETI: begin
                        stk_pop = 1'b1;
                        pc_d    = stk_top;
                        ie_d    = ir_q[0];
                    end
                    FLOW_IESET: ie_d = ir_q[0];
                    default: ;
                endcase
            end
            ST_IACK: begin
                irq_ack   = 1'b1;
                stk_push  = 1'b1;
                stk_wdata = pc_q;
                pc_d      = VECTOR_ADDR;
                ie_d      = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ie_q <= 1'b0;
            ir_q <= '0;
        end else begin
            pc_q <= pc_d;
            ie_q <= ie_d;
            if (state_q == ST_FETCH) ir_q <= instr_word;
        end
    end

    // Cycles an enabled request has waited without acknowledge
    logic [2:0] wait_cnt;
    always_ff @(posedge clk) begin
        if (rst) wait_cnt <= '0;
        else if (irq && ie_q && !irq_ack) wait_cnt <= (wait_cnt == 3'd7) ? wait_cnt : wait_cnt + 3'd1;
        else wait_cnt <= '0;
    end

    assert_irq_latency_R8: assert property (@(posedge clk) disable iff (rst)
        wait_cnt < 3'd5);
    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);
    assert_vector_load_R8: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> (prog_addr == VECTOR_ADDR));
    assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> $stable(prog_addr));
    assert_cond_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && ir_q[OPC_LSB +: OPC_W] == OPC_JUMPC &&
         ir_q[COND_LSB +: 2] == 2'b00 && flag_zero)
        |=> prog_addr == $past(ir_q[ADDR_W-1:0]));
    assert_op_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !op_valid);
    assert_reset_pc_R1: assert property (@(posedge clk)
        rst |=> (prog_addr == '0 && !irq_ack));
endmodule

// File: tb/sim_instr_sequencer.sv
module sim_instr_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  prog_addr;
    logic [17:0] instr_word;
    logic        flag_zero = 1'b0, flag_carry = 1'b0, irq = 1'b0;
    logic        irq_ack, op_valid;
    logic [5:0]  op_code;
    logic [3:0]  op_dst, op_src;
    logic [7:0]  op_imm;

    logic        use_fixed = 1'b1;
    logic [17:0] fixed_instr = 18'h0;
    logic [17:0] mem [1024];

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign instr_word = use_fixed ? fixed_instr : mem[prog_addr];

    instr_sequencer u0 (
        .clk(clk), .rst(rst), .prog_addr(prog_addr), .instr_word(instr_word),
        .flag_zero(flag_zero), .flag_carry(flag_carry), .irq(irq),
        .irq_ack(irq_ack), .op_valid(op_valid), .op_code(op_code),
        .op_dst(op_dst), .op_src(op_src), .op_imm(op_imm)
    );

    // {instr[17:0], zero, carry, taken}
    localparam logic [20:0] VEC [NVEC] = '{
        {6'h20, 2'b00, 10'h100, 1'b0, 1'b0, 1'b1},
        {6'h28, 2'b00, 10'h050, 1'b1, 1'b0, 1'b1},
        {6'h28, 2'b00, 10'h3C0, 1'b0, 1'b1, 1'b0},
        {6'h28, 2'b01, 10'h0A0, 1'b0, 1'b1, 1'b1},
        {6'h28, 2'b01, 10'h3C0, 1'b1, 1'b0, 1'b0},
        {6'h28, 2'b10, 10'h1C0, 1'b0, 1'b1, 1'b1},
        {6'h28, 2'b10, 10'h3C0, 1'b1, 1'b0, 1'b0},
        {6'h28, 2'b11, 10'h2E0, 1'b1, 1'b0, 1'b1},
        {6'h28, 2'b11, 10'h3C0, 1'b0, 1'b1, 1'b0},
        {6'h21, 2'b00, 10'h300, 1'b0, 1'b0, 1'b1},
        {6'h29, 2'b00, 10'h310, 1'b1, 1'b0, 1'b1},
        {6'h29, 2'b11, 10'h320, 1'b0, 1'b1, 1'b0},
        {6'h2A, 2'b10, 10'h000, 1'b1, 1'b0, 1'b0},
        {6'h2A, 2'b01, 10'h000, 1'b0, 1'b0, 1'b1},
        {6'h22, 2'b00, 10'h000, 1'b0, 1'b0, 1'b1},
        {6'h01, 4'h7, 4'hA, 4'h5, 1'b0, 1'b0, 1'b0}
    };

    logic [9:0] mstk [31];
    int msp = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        msp = 0;
    endtask

    task automatic one_instr();
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [17:0] ins;
        logic [5:0]  opc;
        logic [9:0]  cur, exp_pc;
        string       tag;
        int          n;
        int          acks;

        // R1: reset state
        repeat (2) @(negedge clk);
        chk(prog_addr == 10'h000, "R1 prog_addr", prog_addr, 0);
        chk(!irq_ack && !op_valid, "R1 strobes", {irq_ack, op_valid}, 0);
        do_reset();
        chk(prog_addr == 10'h000, "R1 after release", prog_addr, 0);

        // Vector table walk: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NVEC; i++) begin
            ins = VEC[i][20:3];
            opc = ins[17:12];
            fixed_instr = ins;
            flag_zero = VEC[i][2];
            flag_carry = VEC[i][1];
            cur = prog_addr;
            exp_pc = cur + 10'd1;
            tag = (opc[5:4] != 2'b10) ? "R3" : (opc[3] ? "R5" : "R4");
            if ((opc == 6'h20 || opc == 6'h28) && VEC[i][0]) exp_pc = ins[9:0];
            if ((opc == 6'h21 || opc == 6'h29) && VEC[i][0]) begin
                mstk[msp] = cur + 10'd1;
                msp = (msp + 1) % 31;
                exp_pc = ins[9:0];
                tag = "R6 call";
            end
            if ((opc == 6'h22 || opc == 6'h2A) && VEC[i][0]) begin
                msp = (msp + 30) % 31;
                exp_pc = mstk[msp];
                tag = "R6 return";
            end
            @(posedge clk); @(negedge clk);
            chk(prog_addr == cur, "R2 hold in execute", prog_addr, cur);
            chk(op_valid == (opc[5:4] != 2'b10), "R10 op_valid", op_valid, opc[5:4] != 2'b10);
            if (opc[5:4] != 2'b10) begin
                chk(op_code == opc && op_dst == ins[11:8] && op_src == ins[7:4] && op_imm == ins[7:0],
                    "R10 fields", {op_code, op_dst, op_imm}, {opc, ins[11:8], ins[7:0]});
            end
            @(posedge clk); @(negedge clk);
            chk(prog_addr == exp_pc, tag, prog_addr, exp_pc);
            chk(!op_valid, "R10 op_valid low in fetch", op_valid, 0);
        end

        // R3: rollover from 0x3FF to 0x000
        fixed_instr = {6'h20, 2'b00, 10'h3FF};
        one_instr();
        fixed_instr = {6'h02, 12'h000};
        one_instr();
        chk(prog_addr == 10'h000, "R3 rollover", prog_addr, 0);

        // R8: request ignored while enable is clear (R1 left it clear)
        do_reset();
        irq = 1'b1;
        acks = 0;
        fixed_instr = {6'h03, 12'h011};
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); @(negedge clk);
            if (irq_ack) acks++;
        end
        chk(acks == 0, "R8 disabled ignores irq", acks, 0);
        chk(prog_addr == 10'h003, "R8 flow unchanged when disabled", prog_addr, 3);

        // R9/R8: enabling while request pending takes it right after
        fixed_instr = {6'h24, 12'h001};
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk(irq_ack == 1'b1, "R8 ack after enable", irq_ack, 1);
        chk(prog_addr == 10'h004, "R8 next address during ack", prog_addr, 4);
        irq = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(irq_ack == 1'b0, "R8 ack one cycle", irq_ack, 0);
        chk(prog_addr == 10'h3FF, "R8 vector", prog_addr, 10'h3FF);
        fixed_instr = {6'h23, 12'h001};
        one_instr();
        chk(prog_addr == 10'h004, "R9 return to interrupted", prog_addr, 4);

        // R8 latency with enable restored by return-from-interrupt
        fixed_instr = {6'h05, 12'h022};
        irq = 1'b1;
        n = 0;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); @(negedge clk);
            if (irq_ack && n == 0) n = k;
        end
        chk(n >= 1 && n <= 5, "R8 latency", n, 2);
        // ack at k=2, vector fetched k=3, one instruction ran k=3..4, k=5..6 next
        // run a clean sequence from the vector instead
        do_reset();
        fixed_instr = {6'h24, 12'h001};
        one_instr();
        irq = 1'b1;
        fixed_instr = {6'h05, 12'h022};
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk(irq_ack == 1'b1, "R8 ack after ALU instr", irq_ack, 1);
        @(posedge clk); @(negedge clk);
        chk(prog_addr == 10'h3FF, "R8 vector second", prog_addr, 10'h3FF);
        fixed_instr = {6'h23, 12'h000};
        one_instr();
        chk(prog_addr == 10'h002, "R9 return address", prog_addr, 2);
        acks = 0;
        fixed_instr = {6'h05, 12'h022};
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); @(negedge clk);
            if (irq_ack) acks++;
        end
        chk(acks == 0, "R9 enable cleared by return bit", acks, 0);
        irq = 1'b0;

        // R7: 32 nested calls then returns around the 31-entry ring
        do_reset();
        use_fixed = 1'b0;
        for (int a = 0; a < 1024; a++) mem[a] = {6'h02, 12'h000};
        for (int a = 0; a < 32; a++) mem[a] = {6'h21, 2'b00, 10'(a + 1)};
        mem[32] = {6'h22, 12'h000};
        for (int k = 0; k < 32; k++) one_instr();
        chk(prog_addr == 10'd32, "R6 call chain end", prog_addr, 32);
        for (int a = 1; a < 32; a++) mem[a] = {6'h22, 12'h000};
        for (int k = 1; k <= 32; k++) begin
            one_instr();
            exp_pc = (k == 1 || k == 32) ? 10'd32 : 10'(33 - k);
            chk(prog_addr == exp_pc, "R7 ring pop", prog_addr, exp_pc);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule